// File: doc/BRIEF.md
# Interrupt Acceptance and Priority Unit

This unit sits beside a processor's sequencer and decides, once per instruction boundary, whether the core next services a non-maskable interrupt, a maskable interrupt, or carries on. A falling edge on the active-low non-maskable line is caught in a pending latch. The active-low maskable line is treated as a level. The unit owns the two interrupt-enable flip-flops and the 2-bit maskable-interrupt mode register, which the core updates through command strobes.

A decision is taken only in a cycle where the core raises its end-of-instruction strobe and no bus request is active. If wait states keep an instruction open, that strobe is withheld and acceptance is postponed. The decision appears on registered outputs one clock later, as a single-cycle pulse. It tells the core the kind of interrupt and, for the non-maskable case, the restart address and a request to push the program counter. For the maskable case it asks for an acknowledge cycle and reports the current mode. It also produces a wake pulse when the core is halted, so the core can drop its halt indication.

Top module: `intr_accept_unit`

## Requirements
- R1: A change of `nmi_n` from 1 to 0 between two consecutive clock samples makes a non-maskable request pending. The request stays pending until it is accepted. Holding `nmi_n` low creates no further request.
- R2: If a request is pending in a cycle with `instr_end`=1 and `bus_req`=0, it is accepted whatever `int_n`, `iff1` and `halted` are. In the next cycle `accept`=1, `accept_nmi`=1, `restart_addr`=NMI_VEC (default 0x0066), `push_pc`=1 and `ack_cycle`=0, and the request is no longer pending.
- R3: A maskable interrupt is accepted in a cycle with `instr_end`=1, `bus_req`=0, no pending non-maskable request, `int_n`=0 and `iff1`=1. In the next cycle `accept`=1, `accept_nmi`=0, `ack_cycle`=1, `push_pc`=0 and `restart_addr`=0.
- R4: With `int_n`=1 or `iff1`=0, and nothing pending, an instruction end produces no acceptance (`accept`=0 in the next cycle).
- R5: `bus_req`=1 blocks every acceptance in that cycle. A pending non-maskable request stays pending and is accepted at a later instruction end without a bus request.
- R6: No acceptance follows a cycle with `instr_end`=0, however long that lasts, and a pending request survives it.
- R7: Accepting a non-maskable request copies `iff1` into `iff2` and clears `iff1`. Accepting a maskable interrupt clears both.
- R8: In a cycle without acceptance, the enable commands are applied with `ie_clr` first, then `ie_set`, then `ie_restore`. `ie_clr` clears both flip-flops, `ie_set` sets both, and `ie_restore` copies `iff2` into `iff1`. An acceptance in the same cycle overrides all three.
- R9: `im_wr`=1 loads `im_val` into the mode register. `accept_mode` shows, with each accept pulse, the mode held before any write in the accepting cycle.
- R10: `halt_wake` pulses together with `accept` when `halted`=1 in the accepting cycle, and is 0 otherwise.
- R11: After reset all outputs are 0, both flip-flops are clear, the mode is 0 and nothing is pending.
- R12: Every output pulse lasts one cycle unless another acceptance follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| int_n | input | 1 | Maskable request, active low level |
| bus_req | input | 1 | External bus request active; blocks acceptance |
| instr_end | input | 1 | Current instruction completes this cycle |
| halted | input | 1 | Core is in its halt state |
| ie_set | input | 1 | Set both enable flip-flops |
| ie_clr | input | 1 | Clear both enable flip-flops |
| ie_restore | input | 1 | Copy iff2 into iff1 |
| im_wr | input | 1 | Load mode register |
| im_val | input | MODE_W | New mode value |
| accept | output | 1 | Interrupt accepted (pulse) |
| accept_nmi | output | 1 | Accepted interrupt is non-maskable |
| restart_addr | output | ADDR_W | Restart address for a non-maskable accept, else 0 |
| push_pc | output | 1 | Request to stack the program counter |
| ack_cycle | output | 1 | Request for an acknowledge cycle |
| accept_mode | output | MODE_W | Mode reported with the accept |
| halt_wake | output | 1 | Leave halt state |
| iff1 | output | 1 | Primary enable flip-flop |
| iff2 | output | 1 | Backup enable flip-flop |

## Verification
The bench uses the default parameters: a 16-bit restart address equal to 0x0066 and a 2-bit mode register. With 2 bits, all four mode codes, including the unused fourth one, can be written and read back through accept pulses. Random stimulus drives instruction ends, bus requests, edges, enable commands and halt together. This reaches collisions such as an acceptance landing on the same cycle as an enable command, a mode write or a fresh falling edge. Directed sequences cover long instruction-end droughts and bus-request deferral.

// File: rtl/intr_pkg.sv
`timescale 1ns/1ps
package intr_pkg;
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_state_t;

    typedef struct packed {
        logic iff1;
        logic iff2;
    } iff_state_t;
endpackage

// File: rtl/intr_nmi_latch.sv
`timescale 1ns/1ps
module intr_nmi_latch
    import intr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n_i,
    input  logic take_i,
    output logic pend_o
);
    nmi_state_t st_d, st_q;
    logic       fall;

    always_comb begin
        fall       = st_q.prev & ~nmi_n_i;
        st_d.prev  = nmi_n_i;
        st_d.pend  = (st_q.pend & ~take_i) | fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prev && !nmi_n_i) |=> pend_o);
    assert_pend_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !take_i) |=> pend_o);
    assert_pend_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !(st_q.prev && !nmi_n_i)) |=> !pend_o);
endmodule

// File: rtl/intr_iff_regs.sv
`timescale 1ns/1ps
module intr_iff_regs
    import intr_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_take_i,
    input  logic              int_take_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              ie_restore_i,
    input  logic              im_wr_i,
    input  logic [MODE_W-1:0] im_val_i,
    output logic              iff1_o,
    output logic              iff2_o,
    output logic [MODE_W-1:0] mode_o
);
    iff_state_t        ff_d, ff_q;
    logic [MODE_W-1:0] mode_d, mode_q;

    always_comb begin
        ff_d   = ff_q;
        mode_d = im_wr_i ? im_val_i : mode_q;
        if (nmi_take_i) begin
            ff_d.iff2 = ff_q.iff1;
            ff_d.iff1 = 1'b0;
        end else if (int_take_i) begin
            ff_d.iff1 = 1'b0;
            ff_d.iff2 = 1'b0;
        end else if (ie_clr_i) begin
            ff_d.iff1 = 1'b0;
            ff_d.iff2 = 1'b0;
        end else if (ie_set_i) begin
            ff_d.iff1 = 1'b1;
            ff_d.iff2 = 1'b1;
        end else if (ie_restore_i) begin
            ff_d.iff1 = ff_q.iff2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q   <= '0;
            mode_q <= '0;
        end else begin
            ff_q   <= ff_d;
            mode_q <= mode_d;
        end
    end

    assign iff1_o = ff_q.iff1;
    assign iff2_o = ff_q.iff2;
    assign mode_o = mode_q;

    assert_nmi_backup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take_i |=> (!iff1_o && (iff2_o == $past(iff1_o))));
    assert_int_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_take_i |=> (!iff1_o && !iff2_o));
    assert_set_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_set_i && !ie_clr_i && !nmi_take_i && !int_take_i) |=> (iff1_o && iff2_o));
    assert_take_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_take_i && int_take_i));
    assert_mode_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        im_wr_i |=> (mode_o == $past(im_val_i)));
endmodule

// File: rtl/intr_arbiter.sv
`timescale 1ns/1ps
module intr_arbiter #(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter int              MODE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_end_i,
    input  logic              bus_req_i,
    input  logic              pend_i,
    input  logic              int_n_i,
    input  logic              iff1_i,
    input  logic              halted_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              nmi_take_o,
    output logic              int_take_o,
    output logic              accept_o,
    output logic              accept_nmi_o,
    output logic [ADDR_W-1:0] restart_addr_o,
    output logic              push_pc_o,
    output logic              ack_cycle_o,
    output logic [MODE_W-1:0] accept_mode_o,
    output logic              halt_wake_o
);
    typedef struct packed {
        logic              acc;
        logic              nmi;
        logic [ADDR_W-1:0] addr;
        logic              push;
        logic              ack;
        logic [MODE_W-1:0] mode;
        logic              wake;
    } arb_out_t;

    arb_out_t out_d, out_q;
    logic     window;

    always_comb begin
        window     = instr_end_i & ~bus_req_i;
        nmi_take_o = window & pend_i;
        int_take_o = window & ~pend_i & ~int_n_i & iff1_i;
        out_d.acc  = nmi_take_o | int_take_o;
        out_d.nmi  = nmi_take_o;
        out_d.addr = nmi_take_o ? NMI_VEC : '0;
        out_d.push = nmi_take_o;
        out_d.ack  = int_take_o;
        out_d.mode = out_d.acc ? mode_i : '0;
        out_d.wake = out_d.acc & halted_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign accept_o       = out_q.acc;
    assign accept_nmi_o   = out_q.nmi;
    assign restart_addr_o = out_q.addr;
    assign push_pc_o      = out_q.push;
    assign ack_cycle_o    = out_q.ack;
    assign accept_mode_o  = out_q.mode;
    assign halt_wake_o    = out_q.wake;

    assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end_i && !bus_req_i && pend_i) |=> (accept_o && accept_nmi_o && push_pc_o && !ack_cycle_o));
    assert_int_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_i && (int_n_i || !iff1_i)) |=> !accept_o);
    assert_busreq_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_i |=> !accept_o);
    assert_no_end_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_end_i |=> !accept_o);
    assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wake_o |-> accept_o);
    assert_ack_is_int_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cycle_o |-> (accept_o && !accept_nmi_o && !push_pc_o));
endmodule

// File: rtl/intr_accept_unit.sv
`timescale 1ns/1ps
module intr_accept_unit #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter int                MODE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_n,
    input  logic              int_n,
    input  logic              bus_req,
    input  logic              instr_end,
    input  logic              halted,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              ie_restore,
    input  logic              im_wr,
    input  logic [MODE_W-1:0] im_val,
    output logic              accept,
    output logic              accept_nmi,
    output logic [ADDR_W-1:0] restart_addr,
    output logic              push_pc,
    output logic              ack_cycle,
    output logic [MODE_W-1:0] accept_mode,
    output logic              halt_wake,
    output logic              iff1,
    output logic              iff2
);
    logic              pend;
    logic              nmi_take;
    logic              int_take;
    logic [MODE_W-1:0] mode;

    intr_nmi_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n_i (nmi_n),
        .take_i  (nmi_take),
        .pend_o  (pend)
    );

    intr_iff_regs #(.MODE_W(MODE_W)) u_iff (
        .clk          (clk),
        .rst_n        (rst_n),
        .nmi_take_i   (nmi_take),
        .int_take_i   (int_take),
        .ie_set_i     (ie_set),
        .ie_clr_i     (ie_clr),
        .ie_restore_i (ie_restore),
        .im_wr_i      (im_wr),
        .im_val_i     (im_val),
        .iff1_o       (iff1),
        .iff2_o       (iff2),
        .mode_o       (mode)
    );

    intr_arbiter #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC), .MODE_W(MODE_W)) u_arb (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_end_i    (instr_end),
        .bus_req_i      (bus_req),
        .pend_i         (pend),
        .int_n_i        (int_n),
        .iff1_i         (iff1),
        .halted_i       (halted),
        .mode_i         (mode),
        .nmi_take_o     (nmi_take),
        .int_take_o     (int_take),
        .accept_o       (accept),
        .accept_nmi_o   (accept_nmi),
        .restart_addr_o (restart_addr),
        .push_pc_o      (push_pc),
        .ack_cycle_o    (ack_cycle),
        .accept_mode_o  (accept_mode),
        .halt_wake_o    (halt_wake)
    );

    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !instr_end) |=> !accept);
endmodule

// File: tb/intr_accept_unit_bench.sv
`timescale 1ns/1ps
module intr_accept_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_n = 1'b1, int_n = 1'b1, bus_req = 1'b0, instr_end = 1'b0, halted = 1'b0;
    logic ie_set = 1'b0, ie_clr = 1'b0, ie_restore = 1'b0, im_wr = 1'b0;
    logic [1:0]  im_val = 2'd0;
    logic        accept, accept_nmi, push_pc, ack_cycle, halt_wake, iff1, iff2;
    logic [15:0] restart_addr;
    logic [1:0]  accept_mode;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    bit m_prev = 1, m_pend = 0, m_iff1 = 0, m_iff2 = 0;
    bit [1:0] m_mode = 0;
    bit e_acc = 0, e_nmi = 0, e_push = 0, e_ack = 0, e_wake = 0;
    bit [15:0] e_addr = 0;
    bit [1:0]  e_mode = 0;
    string lbl = "R4";

    always #10 clk = ~clk;

    intr_accept_unit u_intr_accept_unit (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n), .bus_req(bus_req),
        .instr_end(instr_end), .halted(halted), .ie_set(ie_set), .ie_clr(ie_clr),
        .ie_restore(ie_restore), .im_wr(im_wr), .im_val(im_val),
        .accept(accept), .accept_nmi(accept_nmi), .restart_addr(restart_addr),
        .push_pc(push_pc), .ack_cycle(ack_cycle), .accept_mode(accept_mode),
        .halt_wake(halt_wake), .iff1(iff1), .iff2(iff2)
    );

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    function automatic string pick_label(bit tn, bit ti, bit br, bit en);
        if (tn) return "R2";
        if (ti) return "R3";
        if (br) return "R5";
        if (!en) return "R6";
        return "R4";
    endfunction

    // one clock: drive at negedge, predict, sample at next negedge
    task automatic step(input bit nmi, input bit intn, input bit en, input bit br, input bit hl,
                        input bit s, input bit c, input bit r, input bit w, input bit [1:0] v);
        bit fall, tn, ti;
        nmi_n = nmi; int_n = intn; instr_end = en; bus_req = br; halted = hl;
        ie_set = s; ie_clr = c; ie_restore = r; im_wr = w; im_val = v;
        fall = m_prev & ~nmi;
        tn = en & ~br & m_pend;
        ti = en & ~br & ~m_pend & ~intn & m_iff1;
        e_acc = tn | ti; e_nmi = tn; e_push = tn; e_ack = ti;
        e_addr = tn ? 16'h0066 : 16'h0000;
        e_mode = (tn | ti) ? m_mode : 2'd0;
        e_wake = (tn | ti) & hl;
        lbl = pick_label(tn, ti, br, en);
        if (tn) begin m_iff2 = m_iff1; m_iff1 = 0; end
        else if (ti) begin m_iff1 = 0; m_iff2 = 0; end
        else if (c) begin m_iff1 = 0; m_iff2 = 0; end
        else if (s) begin m_iff1 = 1; m_iff2 = 1; end
        else if (r) m_iff1 = m_iff2;
        if (w) m_mode = v;
        m_pend = (m_pend & ~tn) | fall;
        m_prev = nmi;
        @(posedge clk);
        @(negedge clk);
        chk(lbl, "accept", {15'd0, accept}, {15'd0, e_acc});
        chk(lbl, "kind", {15'd0, accept_nmi}, {15'd0, e_nmi});
        chk(lbl, "addr", restart_addr, e_addr);
        chk(lbl, "push", {15'd0, push_pc}, {15'd0, e_push});
        chk(lbl, "ack", {15'd0, ack_cycle}, {15'd0, e_ack});
        chk("R9", "mode", {14'd0, accept_mode}, {14'd0, e_mode});
        chk("R10", "wake", {15'd0, halt_wake}, {15'd0, e_wake});
        chk((tn | ti) ? "R7" : "R8", "iff1", {15'd0, iff1}, {15'd0, m_iff1});
        chk((tn | ti) ? "R7" : "R8", "iff2", {15'd0, iff2}, {15'd0, m_iff2});
    endtask

    task automatic idle(input bit nmi, input int n);
        for (int i = 0; i < n; i++) step(nmi, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL R6 watchdog: got=timeout exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit nl;
        bit [31:0] r;
        void'($urandom(32'h1d5a7c3));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "accept", {15'd0, accept}, 16'd0);
        chk("R11", "addr", restart_addr, 16'd0);
        chk("R11", "iff1", {15'd0, iff1}, 16'd0);
        chk("R11", "iff2", {15'd0, iff2}, 16'd0);
        chk("R11", "mode", {14'd0, accept_mode}, 16'd0);

        // R1/R2: edge while iff off and int low; accepted regardless
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: long wait with no instruction end, pending survives
        idle(0, 40);
        // R5: bus request at end defers
        step(0, 0, 1, 1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 1, 0, 0, 0, 0, 0);   // R2 accept, halted -> R10 wake
        // R1: held low, no retrigger
        step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        // R8 set, then R3 int accepted with mode 2, R12 single pulse
        step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 1, 0, 0, 0, 1, 2'd3);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R4: int low but iff cleared
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R7: nmi backup with iff1 set, then R8 restore
        step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 1, 1, 0, 0, 0);   // accept overrides commands
        step(0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
        step(1, 1, 0, 0, 0, 1, 1, 1, 0, 0);   // clr wins over set

        nl = 1;
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            if (r[3:0] < 2) nl = ~nl;
            step(nl, r[6:5] != 0 ? r[4] : 1'b0, r[9:7] < 3, r[12:10] < 2, r[14:13] == 0,
                 r[19:15] == 0, r[24:20] == 0, r[28:25] == 0, r[30:29] == 0, r[2:1] ^ r[31:30]);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule